// File: doc/BRIEF.md
# Interrupt Mask Register Bank

This block holds a 64-bit interrupt mask for an interrupt controller and presents it on a word-wide register bus. The mask is split into a high word for bits 63:32 and a low word for bits 31:0. A mask bit at 1 blocks its source, and a mask bit at 0 lets it through. Bit 0 of the low word does not belong to any source. It is a mask-all control: a write that sets it drives every mask bit to one in the same cycle.

Raw request lines go through a two-flop synchroniser into a pending vector. The pending vector shows each request whether or not the source is masked. The bus can read it as two read-only words. The block also produces a masked request vector for the downstream priority logic. Bit n of that vector (n = 1..63) is pending[n] AND NOT mask[n], and bit 0 is always zero.

Top module: `irq_mask_bank`

## Requirements
- R1: After reset every mask bit is 1. Both mask words read 0xFFFFFFFF and the masked request output is all zero.
- R2: The mask high word (bits 63:32) is read and written at byte offset 0x08. The mask low word (bits 31:0) is read and written at byte offset 0x0C. A write takes effect on the rising edge at which wr_en_i is high.
- R3: Write strobe bit b enables data byte b (bits 8b+7:8b) of the addressed word. A byte whose strobe is low keeps its old value.
- R4: A write to offset 0x0C with wstrb_i[0]=1 and wdata_i[0]=1 sets all 64 mask bits to 1 on that same edge, whatever the other data and strobe bits are.
- R5: A write to offset 0x0C with wdata_i[0]=1 and wstrb_i[0]=0 does not trigger mask-all. The other bytes are written normally and the high word is unchanged.
- R6: Offset 0x00 reads pending bits 63:32 and offset 0x04 reads pending bits 31:0. Pending shows the raw request state even when the matching mask bit is 1.
- R7: Writes to offsets 0x00 and 0x04 are ignored. Neither the mask nor the pending view changes.
- R8: For n = 1..63, masked_req_o[n] = pending[n] AND NOT mask[n]. masked_req_o[0] is always 0.
- R9: Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return zero, and writes to them change nothing.
- R10: A change on req_i appears in pending after the second rising edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 64 | Raw interrupt request lines |
| addr_i | input | 5 | Byte offset of the register access |
| wr_en_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Per-byte write strobes |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| masked_req_o | output | 64 | Requests that are pending and not masked |

## Verification
Register reads are combinational. The bench therefore checks read data on the falling edge after it sets the address, and checks a written value on the falling edge after the capturing rising edge. Pending and masked requests trail req_i by two rising edges. For R10 the bench samples on the falling edges after the first edge and after the second, and expects the old value and then the new one. All inputs change on falling edges, so no check depends on the order of processes at a rising edge.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int NUM_SRC = 2 * DATA_W;
  localparam int WSEL_W = ADDR_W - 2;

  typedef enum logic [WSEL_W-1:0] {
    SEL_PEND_HI = 3'd0,
    SEL_PEND_LO = 3'd1,
    SEL_MASK_HI = 3'd2,
    SEL_MASK_LO = 3'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] meta_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      pend_q <= '0;
    end else begin
      meta_q <= req_i;
      pend_q <= meta_q;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_mask_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW/8-1:0] wstrb_i,
  output logic [2*DW-1:0] mask_o
);
  localparam int NB = DW / 8;

  logic [2*DW-1:0] mask_q, mask_d;
  logic            wr_hi, wr_lo, mask_all;

  assign wr_hi    = wr_en_i && (wsel_i == SEL_MASK_HI);
  assign wr_lo    = wr_en_i && (wsel_i == SEL_MASK_LO);
  assign mask_all = wr_lo && wstrb_i[0] && wdata_i[0];

  always_comb begin
    mask_d = mask_q;
    for (int b = 0; b < NB; b++) begin
      if (wr_hi && wstrb_i[b]) mask_d[DW+8*b +: 8] = wdata_i[8*b +: 8];
      if (wr_lo && wstrb_i[b]) mask_d[8*b +: 8]    = wdata_i[8*b +: 8];
    end
    if (mask_all) mask_d = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wsel_i == SEL_MASK_LO && wstrb_i[0] && wdata_i[0]) |=> (&mask_o)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_o)); // R2
  AST_PEND_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wsel_i == SEL_PEND_HI || wsel_i == SEL_PEND_LO)) |=> $stable(mask_o)); // R7
  AST_UNMAPPED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wsel_i > SEL_MASK_LO) |=> $stable(mask_o)); // R9
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_mask_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [2*DW-1:0]   pend_i,
  input  logic [2*DW-1:0]   mask_i,
  output logic [DW-1:0]     rdata_o
);
  always_comb begin
    unique case (wsel_i)
      SEL_PEND_HI: rdata_o = pend_i[2*DW-1:DW];
      SEL_PEND_LO: rdata_o = pend_i[DW-1:0];
      SEL_MASK_HI: rdata_o = mask_i[2*DW-1:DW];
      SEL_MASK_LO: rdata_o = mask_i[DW-1:0];
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_mask_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2*DW-1:0] req_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW/8-1:0] wstrb_i,
  output logic [DW-1:0]   rdata_o,
  output logic [2*DW-1:0] masked_req_o
);
  localparam int NSRC = 2 * DW;

  logic [NSRC-1:0]   pend, mask;
  logic [WSEL_W-1:0] wsel;

  assign wsel = addr_i[AW-1:2];

  irq_req_sync #(.WIDTH(NSRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .pend_o(pend)
  );

  irq_mask_regs #(.DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wsel_i(wsel),
    .wdata_i(wdata_i), .wstrb_i(wstrb_i), .mask_o(mask)
  );

  irq_read_mux #(.DW(DW)) u_rd (
    .wsel_i(wsel), .pend_i(pend), .mask_i(mask), .rdata_o(rdata_o)
  );

  // bit 0 is the mask-all control, never a source
  assign masked_req_o = {pend[NSRC-1:1] & ~mask[NSRC-1:1], 1'b0};

  AST_MASKED_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((masked_req_o & mask) == '0) && ((masked_req_o & ~pend) == '0)); // R8
endmodule

// File: tb/irq_mask_bank_tb_top.sv
module irq_mask_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] req_i = '0;
  logic [4:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  wstrb_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] masked_req_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  irq_mask_bank dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wstrb_i = s; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wstrb_i = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(5'h08, d); chk("R1 mask hi", d, 32'hFFFF_FFFF);
    rd(5'h0C, d); chk("R1 mask lo", d, 32'hFFFF_FFFF);
    chk("R1 masked req", masked_req_o, '0);
  endtask

  task automatic t_rw;
    logic [31:0] d;
    wr(5'h08, 32'h1234_5678, 4'hF);
    rd(5'h08, d); chk("R2 hi write", d, 32'h1234_5678);
    wr(5'h0C, 32'hCAFE_0002, 4'hF);
    rd(5'h0C, d); chk("R2 lo write", d, 32'hCAFE_0002);
    rd(5'h08, d); chk("R2 hi kept", d, 32'h1234_5678);
  endtask

  task automatic t_strobe;
    logic [31:0] d;
    wr(5'h08, 32'hFFFF_FFFF, 4'hF);
    wr(5'h08, 32'h1234_5678, 4'b0101);
    rd(5'h08, d); chk("R3 byte strobes", d, 32'hFF34_FF78);
  endtask

  task automatic t_maskall_nostrobe;
    logic [31:0] d;
    wr(5'h08, 32'h0, 4'hF);
    wr(5'h0C, 32'h0, 4'hF);
    wr(5'h0C, 32'hAB00_0001, 4'b1110);
    rd(5'h0C, d); chk("R5 lo bytes", d, 32'hAB00_0000);
    rd(5'h08, d); chk("R5 hi unchanged", d, 32'h0);
  endtask

  task automatic t_maskall;
    logic [31:0] d;
    wr(5'h0C, 32'h0, 4'hF);
    wr(5'h08, 32'h0, 4'hF);
    wr(5'h0C, 32'h0000_0001, 4'b0001);
    rd(5'h08, d); chk("R4 hi all ones", d, 32'hFFFF_FFFF);
    rd(5'h0C, d); chk("R4 lo all ones", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk_i);
    req_i = 64'h8000_0000_0000_0010;
    @(negedge clk_i);
    rd(5'h04, d); chk("R10 after first edge", d, 32'h0);
    @(negedge clk_i);
    rd(5'h04, d); chk("R10 after second edge", d, 32'h0000_0010);
  endtask

  task automatic t_pending;
    logic [31:0] d;
    rd(5'h00, d); chk("R6 pend hi masked", d, 32'h8000_0000);
    rd(5'h04, d); chk("R6 pend lo masked", d, 32'h0000_0010);
    chk("R8 all masked", masked_req_o, '0);
  endtask

  task automatic t_pend_write;
    logic [31:0] d;
    wr(5'h00, 32'h0, 4'hF);
    wr(5'h04, 32'h0, 4'hF);
    rd(5'h00, d); chk("R7 pend hi kept", d, 32'h8000_0000);
    rd(5'h04, d); chk("R7 pend lo kept", d, 32'h0000_0010);
    rd(5'h08, d); chk("R7 mask hi kept", d, 32'hFFFF_FFFF);
    rd(5'h0C, d); chk("R7 mask lo kept", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_masked;
    wr(5'h08, 32'h0, 4'hF);
    wr(5'h0C, 32'h0000_00F0, 4'hF);
    @(negedge clk_i);
    req_i = 64'hA5A5_0000_0000_00FF;
    @(negedge clk_i);
    @(negedge clk_i);
    #1 chk("R8 masked pattern", masked_req_o, 64'hA5A5_0000_0000_000E);
    wr(5'h08, 32'hFF00_0000, 4'hF);
    #1 chk("R8 hi partly masked", masked_req_o, 64'h00A5_0000_0000_000E);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(5'h10, d); chk("R9 read 0x10", d, 32'h0);
    rd(5'h1C, d); chk("R9 read 0x1C", d, 32'h0);
    wr(5'h14, 32'h0, 4'hF);
    rd(5'h08, d); chk("R9 hi kept", d, 32'hFF00_0000);
    rd(5'h0C, d); chk("R9 lo kept", d, 32'h0000_00F0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset;
        t_rw;
        t_strobe;
        t_maskall_nostrobe;
        t_maskall;
        t_sync;
        t_pending;
        t_pend_write;
        t_masked;
        t_unmapped;
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule